// File: doc/BRIEF.md
# ADC SPI Command Sequencer

This block is an SPI master for a multi-channel delta-sigma converter. After reset it assumes the converter is streaming conversion results, so it first sends a stop-continuous-read command. After that it carries out register read and write requests from a host. The host side is a single valid/ready request port that carries:

- a direction bit,
- a 5-bit start address,
- a register count,
- up to `MAX_REGS` bytes of write data.

Each returned read byte is presented for one cycle with a valid strobe.

Every gap in a frame is a minimum counted in system clock cycles, not in SCLK periods. This covers:

- chip-select setup before the first SCLK,
- the decode wait after each byte that is followed by another,
- chip-select hold after the last SCLK,
- chip-select high time between frames.

Raising the SCLK rate through the `half_div` input therefore never shortens these gaps below their limits.

The converter's START pin is driven low whenever a frame is in progress or pending, so conversions never overlap command traffic. The data-ready strobe from the converter is ignored by the sequencer: a trailing pulse after the stop command cannot be mistaken for data.

Top module: `adc_cmd_seq`

## Requirements
- R1: After reset, before any request is accepted, the block sends a frame of exactly one byte, 0x11 (stop continuous read). `busy` is high and `req_ready` is low until that frame has finished.
- R2: A read frame is, in order, all under one chip-select assertion:
  - byte 0x20 OR address (address in bits 4:0),
  - byte `req_nregs_m1` (number of registers minus one),
  - one 0x00 byte per register.

  Each byte captured during those 0x00 bytes appears on `rd_data` with a one-cycle `rd_valid`, in ascending address order.
- R3: A write frame is, in order: byte 0x40 OR address, then `req_nregs_m1`, then the data bytes. The data bytes are taken from `req_wdata` lowest byte first, and that first data byte goes to the start address.
- R4: Between the 8th falling SCLK edge of a byte and the first rising edge of the next byte in the same frame, at least `DECODE_CYC` system clock cycles pass, for every value of `half_div`.
- R5: At least `HOLD_CYC` system clock cycles pass between the last falling SCLK edge of a frame and the rise of chip select.
- R6: At least `SETUP_CYC` cycles pass between the fall of chip select and the first rising SCLK edge. Chip select stays high for at least `IDLE_CYC` cycles between frames. SCLK is low whenever chip select is high.
- R7: SCLK idles low and each of its phases lasts `half_div` cycles. MOSI changes only together with a rising SCLK edge, so it is stable at the falling edge. MISO is sampled on the falling edge. Bytes travel MSB first.
- R8: `adc_start` follows `conv_en` only while the block is idle with `req_ready` high; otherwise it is low, and in particular it is low whenever chip select is low.
- R9: `adc_drdy_n` has no effect. `rd_valid` pulses exactly once per register read, whatever DRDY does during the frame.
- R10: `req_ready` is high only when the block is idle with chip select released. A request is taken on `req_valid && req_ready`. `busy` is the inverse of `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | System cycles per SCLK phase (at least 1) |
| conv_en | input | 1 | Host wish to run conversions while idle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 for register write, 0 for read |
| req_addr | input | 5 | Start register address |
| req_nregs_m1 | input | CNT_W | Register count minus one |
| req_wdata | input | 8*MAX_REGS | Write bytes, lowest byte first |
| busy | output | 1 | Frame in progress or power-up command pending |
| rd_valid | output | 1 | One-cycle strobe for a read byte |
| rd_data | output | 8 | Read byte |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_sclk | output | 1 | Serial clock |
| adc_mosi | output | 1 | Serial data to converter |
| adc_miso | input | 1 | Serial data from converter |
| adc_start | output | 1 | Conversion start pin |
| adc_drdy_n | input | 1 | Data-ready strobe from converter, active low |

## Verification
The assertions take for granted that `half_div` is never zero and only changes while `req_ready` is high. They also assume the register count and write data stay valid in the cycle a request is taken. The stimulus changes `half_div` only between frames, after `busy` has fallen. It drives request fields together with `req_valid` and keeps them until the handshake edge. It toggles DRDY and MISO only away from the clock edge, driving MISO from a converter model that reacts to the rising SCLK edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_GAP,
    ST_HOLD,
    ST_CSHI
  } seq_state_t;

  // Command codes decoded by the converter.
  localparam logic [7:0] OP_STOP_CONT = 8'h11;
  localparam logic [7:0] OP_RD_BASE   = 8'h20;
  localparam logic [7:0] OP_WR_BASE   = 8'h40;

  function automatic logic [7:0] reg_opcode(input logic wr, input logic [4:0] addr);
    return (wr ? OP_WR_BASE : OP_RD_BASE) | {3'b000, addr};
  endfunction

  // Byte placed on the wire at a given frame slot.
  function automatic logic [7:0] frame_byte(input logic is_op, input logic is_cnt,
                                            input logic [7:0] op, input logic [7:0] cnt,
                                            input logic [7:0] data, input logic wr);
    if (is_op)       return op;
    else if (is_cnt) return cnt;
    else if (wr)     return data;
    else             return 8'h00;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/adc_seq_byte_engine.sv
module adc_seq_byte_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             done,
  output logic [7:0]       rx_byte
);

  logic             act_q;
  logic             sclk_q;
  logic             done_q;
  logic [7:0]       sh_q;
  logic [7:0]       rx_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] cnt_q;

  function automatic logic phase_end(input logic [DIV_W-1:0] c, input logic [DIV_W-1:0] h);
    return c == (h - DIV_W'(1));
  endfunction

  // Named events for the checks below.
  logic sclk_fall_ev;
  assign sclk_fall_ev = act_q && sclk_q && phase_end(cnt_q, half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= 8'h00;
      rx_q   <= 8'h00;
      bit_q  <= 3'd0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start) begin
          act_q  <= 1'b1;
          sclk_q <= 1'b1;
          sh_q   <= tx_byte;
          cnt_q  <= '0;
          bit_q  <= 3'd0;
        end
      end else if (phase_end(cnt_q, half_div)) begin
        cnt_q <= '0;
        if (sclk_q) begin
          sclk_q <= 1'b0;
          rx_q   <= {rx_q[6:0], miso};
          if (bit_q == 3'd7) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          sclk_q <= 1'b1;
          bit_q  <= bit_q + 3'd1;
          sh_q   <= {sh_q[6:0], 1'b0};
        end
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = sh_q[7];
  assign done    = done_q;
  assign rx_byte = rx_q;

  // R7: data into the converter does not move at its sampling edge
  p_mosi_still_at_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_fall_ev |=> $stable(mosi));
  // R7: clock rests low outside a byte
  p_sclk_rest_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sclk_q);
  // R7: completion is a single-cycle strobe
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/adc_seq_gap_timer.sv
module adc_seq_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);

  // R4: an expired wait stays expired until reloaded
  p_expired_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq
  import adc_seq_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int MAX_REGS   = 4,
  parameter int DECODE_CYC = 100,
  parameter int SETUP_CYC  = 4,
  parameter int HOLD_CYC   = 20,
  parameter int IDLE_CYC   = 8,
  localparam int CNT_W     = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIV_W-1:0]        half_div,
  input  logic                    conv_en,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [4:0]              req_addr,
  input  logic [CNT_W-1:0]        req_nregs_m1,
  input  logic [MAX_REGS*8-1:0]   req_wdata,
  output logic                    busy,
  output logic                    rd_valid,
  output logic [7:0]              rd_data,
  output logic                    adc_cs_n,
  output logic                    adc_sclk,
  output logic                    adc_mosi,
  input  logic                    adc_miso,
  output logic                    adc_start,
  input  logic                    adc_drdy_n
);

  localparam int BIDX_W   = $clog2(MAX_REGS + 2);
  localparam int MAX_WAIT = max4(DECODE_CYC, SETUP_CYC, HOLD_CYC, IDLE_CYC);
  localparam int TMR_W    = $clog2(MAX_WAIT + 2);

  seq_state_t state_q, nxt;
  logic                  boot_pend_q;
  logic                  rd_q, wr_q;
  logic [7:0]            op_q;
  logic [CNT_W-1:0]      nm1_q;
  logic [MAX_REGS*8-1:0] wd_q;
  logic [BIDX_W-1:0]     idx_q, last_q;
  logic                  cs_n_q;

  logic                  eng_start, eng_done;
  logic [7:0]            eng_tx, eng_rx;
  logic                  tmr_load, tmr_zero;
  logic [TMR_W-1:0]      tmr_val;

  // Named events
  logic start_frame, byte_done, last_byte, in_data_slot;
  assign start_frame  = (state_q == ST_IDLE) && (boot_pend_q || req_valid);
  assign byte_done    = (state_q == ST_SHIFT) && eng_done;
  assign last_byte    = (idx_q == last_q);
  assign in_data_slot = (idx_q >= BIDX_W'(2));

  function automatic logic [TMR_W-1:0] wait_for(input seq_state_t s);
    case (s)
      ST_SETUP: return TMR_W'(SETUP_CYC);
      ST_GAP:   return TMR_W'(DECODE_CYC);
      ST_HOLD:  return TMR_W'(HOLD_CYC);
      ST_CSHI:  return TMR_W'(IDLE_CYC);
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    nxt = state_q;
    case (state_q)
      ST_IDLE:  if (start_frame) nxt = ST_SETUP;
      ST_SETUP: if (tmr_zero)    nxt = ST_SHIFT;
      ST_SHIFT: if (eng_done)    nxt = last_byte ? ST_HOLD : ST_GAP;
      ST_GAP:   if (tmr_zero)    nxt = ST_SHIFT;
      ST_HOLD:  if (tmr_zero)    nxt = ST_CSHI;
      ST_CSHI:  if (tmr_zero)    nxt = ST_IDLE;
      default:                   nxt = ST_IDLE;
    endcase
    tmr_load = (nxt != state_q);
    tmr_val  = wait_for(nxt);
  end

  assign eng_start = (nxt == ST_SHIFT) && (state_q != ST_SHIFT);
  assign eng_tx    = frame_byte(idx_q == '0, idx_q == BIDX_W'(1), op_q,
                                8'(nm1_q), wd_q[7:0], wr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      boot_pend_q <= 1'b1;
      rd_q        <= 1'b0;
      wr_q        <= 1'b0;
      op_q        <= 8'h00;
      nm1_q       <= '0;
      wd_q        <= '0;
      idx_q       <= '0;
      last_q      <= '0;
      cs_n_q      <= 1'b1;
    end else begin
      state_q <= nxt;
      if (start_frame) begin
        cs_n_q <= 1'b0;
        idx_q  <= '0;
        if (boot_pend_q) begin
          boot_pend_q <= 1'b0;
          op_q        <= OP_STOP_CONT;
          rd_q        <= 1'b0;
          wr_q        <= 1'b0;
          nm1_q       <= '0;
          wd_q        <= '0;
          last_q      <= '0;
        end else begin
          op_q   <= reg_opcode(req_write, req_addr);
          rd_q   <= !req_write;
          wr_q   <= req_write;
          nm1_q  <= req_nregs_m1;
          wd_q   <= req_wdata;
          last_q <= BIDX_W'(req_nregs_m1) + BIDX_W'(2);
        end
      end
      if (byte_done && !last_byte) begin
        idx_q <= idx_q + BIDX_W'(1);
        if (in_data_slot) wd_q <= wd_q >> 8;
      end
      if (state_q == ST_HOLD && tmr_zero) cs_n_q <= 1'b1;
    end
  end

  adc_seq_byte_engine #(.DIV_W(DIV_W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .half_div(half_div),
    .start   (eng_start),
    .tx_byte (eng_tx),
    .miso    (adc_miso),
    .sclk    (adc_sclk),
    .mosi    (adc_mosi),
    .done    (eng_done),
    .rx_byte (eng_rx)
  );

  adc_seq_gap_timer #(.W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  assign req_ready = (state_q == ST_IDLE) && !boot_pend_q;
  assign busy      = !req_ready;
  assign adc_start = conv_en && req_ready;
  assign rd_valid  = byte_done && rd_q && in_data_slot;
  assign rd_data   = eng_rx;
  assign adc_cs_n  = cs_n_q;

  // ---------------- checks ----------------
  logic [TMR_W-1:0] since_done_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_done_q <= '0;
    else if (eng_done)              since_done_q <= '0;
    else if (since_done_q != '1)    since_done_q <= since_done_q + TMR_W'(1);
  end

  logic drdy_in_frame;
  assign drdy_in_frame = !adc_drdy_n && !adc_cs_n;

  p_decode_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && state_q == ST_GAP) |-> since_done_q >= TMR_W'(DECODE_CYC));
  p_cs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> $past(since_done_q) >= TMR_W'(HOLD_CYC));
  p_sclk_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);
  p_start_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n |-> !adc_start);
  p_drdy_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drdy_in_frame && !eng_done) |-> !rd_valid);
  p_ready_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (adc_cs_n && !busy));

endmodule

// File: tb/adc_cmd_seq_tb_top.sv
module adc_cmd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DECODE = 100, SETUP = 4, HOLD = 20, IDLE = 8;

  logic clk, rst_n, conv_en, req_valid, req_ready, req_write, busy, rd_valid;
  logic [7:0] half_div, rd_data;
  logic [4:0] req_addr;
  logic [1:0] req_nregs_m1;
  logic [31:0] req_wdata;
  logic adc_cs_n, adc_sclk, adc_mosi, adc_miso, adc_start, adc_drdy_n;

  adc_cmd_seq #(.DIV_W(8), .MAX_REGS(4), .DECODE_CYC(DECODE), .SETUP_CYC(SETUP),
                .HOLD_CYC(HOLD), .IDLE_CYC(IDLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .conv_en(conv_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_nregs_m1(req_nregs_m1), .req_wdata(req_wdata),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_mosi(adc_mosi), .adc_miso(adc_miso),
    .adc_start(adc_start), .adc_drdy_n(adc_drdy_n));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- converter model and timing monitor ----------------
  logic [7:0] model [32];
  logic [7:0] fr [8];
  logic [7:0] lf [8];
  logic [7:0] boot_fr0, shreg;
  logic [7:0] rd_buf [8];
  int fr_n, lf_n, boot_n, bitc, frames, rd_n, cyc, k;
  int cs_fall_cyc, cs_rise_cyc, last8_cyc, rise_cyc;
  bit cs_rise_seen, first_rise;
  int min_gap, min_hold, min_setup, min_idle;
  int mosi_viol, start_viol, ready_viol, hw_viol;
  logic prev_cs, prev_sclk, prev_mosi;

  task automatic reset_mins();
    min_gap = 1 << 30; min_hold = 1 << 30; min_setup = 1 << 30; min_idle = 1 << 30;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'(i * 37 + 5);
    fr_n = 0; lf_n = 0; boot_n = 0; bitc = 0; frames = 0; rd_n = 0; cyc = 0;
    cs_fall_cyc = 0; cs_rise_cyc = 0; last8_cyc = 0; rise_cyc = 0;
    cs_rise_seen = 0; first_rise = 0; shreg = 0; boot_fr0 = 0;
    mosi_viol = 0; start_viol = 0; ready_viol = 0; hw_viol = 0;
    prev_cs = 1; prev_sclk = 0; prev_mosi = 0; adc_miso = 0;
    reset_mins();
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !adc_cs_n) begin
        cs_fall_cyc = cyc;
        if (cs_rise_seen && cyc - cs_rise_cyc < min_idle) min_idle = cyc - cs_rise_cyc;
        fr_n = 0; bitc = 0; first_rise = 1;
      end
      if (!adc_cs_n) begin
        if (!prev_sclk && adc_sclk) begin
          rise_cyc = cyc;
          if (first_rise) begin
            if (cyc - cs_fall_cyc < min_setup) min_setup = cyc - cs_fall_cyc;
            first_rise = 0;
          end else if (bitc == 0 && cyc - last8_cyc < min_gap) min_gap = cyc - last8_cyc;
          if (fr_n >= 2 && fr[0][7:5] == 3'b001) begin
            k = (int'(fr[0][4:0]) + fr_n - 2) % 32;
            adc_miso = model[k][7 - bitc];
          end else adc_miso = 1'b0;
        end
        if (prev_sclk && !adc_sclk) begin
          if (cyc - rise_cyc != int'(half_div)) hw_viol++;
          if (adc_mosi !== prev_mosi) mosi_viol++;
          shreg = {shreg[6:0], adc_mosi};
          bitc++;
          if (bitc == 8) begin
            bitc = 0;
            if (fr_n < 8) fr[fr_n] = shreg;
            fr_n++;
            last8_cyc = cyc;
          end
        end
        if (adc_start) start_viol++;
        if (req_ready) ready_viol++;
      end
      if (!prev_cs && adc_cs_n) begin
        if (cyc - last8_cyc < min_hold) min_hold = cyc - last8_cyc;
        cs_rise_cyc = cyc; cs_rise_seen = 1;
        if (frames == 0) begin boot_n = fr_n; boot_fr0 = fr[0]; end
        frames++;
        lf = fr; lf_n = fr_n;
        if (fr_n >= 3 && fr[0][7:5] == 3'b010)
          for (int j = 0; j <= int'(fr[1]) && j < 6; j++)
            model[(int'(fr[0][4:0]) + j) % 32] = fr[2 + j];
      end
      if (rd_valid) begin
        if (rd_n < 8) rd_buf[rd_n] = rd_data;
        rd_n++;
      end
    end
    prev_cs = adc_cs_n; prev_sclk = adc_sclk; prev_mosi = adc_mosi;
  end

  // ---------------- helpers ----------------
  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic issue(input bit wr, input logic [4:0] a, input logic [1:0] nm1, input logic [31:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_nregs_m1 = nm1; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic check_timing(input string tag);
    check(min_gap >= DECODE, "R4", {tag, " decode gap"}, min_gap, DECODE);
    check(min_hold >= HOLD, "R5", {tag, " cs hold"}, min_hold, HOLD);
    check(min_setup >= SETUP, "R6", {tag, " cs setup"}, min_setup, SETUP);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 0; conv_en = 1; half_div = 8'd2; req_valid = 0; req_write = 0;
    req_addr = 0; req_nregs_m1 = 0; req_wdata = 0; adc_drdy_n = 1;
    repeat (4) @(negedge clk);
    check(adc_cs_n == 1'b1, "R6", "reset cs_n", int'(adc_cs_n), 1);
    check(adc_sclk == 1'b0, "R7", "reset sclk", int'(adc_sclk), 0);
    check(req_ready == 1'b0 && busy == 1'b1, "R1", "reset ready/busy", int'(req_ready), 0);
    check(adc_start == 1'b0, "R8", "reset start", int'(adc_start), 0);
  endtask

  task automatic t_boot();
    rst_n = 1;
    wait_idle();
    check(frames == 1 && boot_n == 1, "R1", "boot frame length", boot_n, 1);
    check(boot_fr0 == 8'h11, "R1", "boot opcode", int'(boot_fr0), 'h11);
    check(req_ready == 1'b1 && busy == 1'b0, "R10", "ready after boot", int'(req_ready), 1);
    check(adc_start == 1'b1, "R8", "start follows conv_en when idle", int'(adc_start), 1);
  endtask

  task automatic t_write(input logic [4:0] a, input logic [1:0] nm1, input logic [31:0] wd, input logic [7:0] hd);
    int ok = 1;
    half_div = hd; reset_mins();
    issue(1, a, nm1, wd);
    wait_idle();
    check(lf_n == int'(nm1) + 3, "R3", "write frame length", lf_n, int'(nm1) + 3);
    check(lf[0] == (8'h40 | {3'b0, a}), "R3", "write opcode", int'(lf[0]), int'(8'h40 | {3'b0, a}));
    check(lf[1] == 8'(nm1), "R3", "write count byte", int'(lf[1]), int'(nm1));
    for (int j = 0; j <= int'(nm1); j++)
      if (lf[2 + j] != wd[8*j +: 8]) ok = 0;
    check(ok == 1, "R3", "write data order", ok, 1);
    check_timing("write");
  endtask

  task automatic t_read(input logic [4:0] a, input logic [1:0] nm1, input logic [7:0] hd);
    logic [7:0] expv [4];
    int ok = 1;
    for (int j = 0; j < 4; j++) expv[j] = model[(int'(a) + j) % 32];
    half_div = hd; reset_mins(); rd_n = 0;
    fork
      begin issue(0, a, nm1, 32'h0); wait_idle(); end
      begin
        repeat (3) begin
          repeat (90) @(negedge clk);
          adc_drdy_n = 0; @(negedge clk); adc_drdy_n = 1;
        end
      end
    join
    check(lf_n == int'(nm1) + 3, "R2", "read frame length", lf_n, int'(nm1) + 3);
    check(lf[0] == (8'h20 | {3'b0, a}), "R2", "read opcode", int'(lf[0]), int'(8'h20 | {3'b0, a}));
    check(lf[1] == 8'(nm1) && lf[2] == 8'h00, "R2", "read count/dummy", int'(lf[1]), int'(nm1));
    check(rd_n == int'(nm1) + 1, "R9", "rd_valid count with DRDY pulses", rd_n, int'(nm1) + 1);
    for (int j = 0; j <= int'(nm1); j++)
      if (rd_buf[j] != expv[j]) begin
        ok = 0;
        $display("FAIL R2 read byte %0d: actual %0d expected %0d", j, rd_buf[j], expv[j]);
      end
    check(ok == 1, "R2", "read data", ok, 1);
    check_timing("read");
  endtask

  task automatic t_back_to_back();
    half_div = 8'd1; reset_mins();
    issue(1, 5'd20, 2'd0, 32'h0000_005A);
    @(negedge clk);
    check(busy == 1'b1 && req_ready == 1'b0, "R10", "busy during frame", int'(busy), 1);
    issue(0, 5'd20, 2'd0, 32'h0);
    wait_idle();
    check(min_idle >= IDLE, "R6", "cs high between frames", min_idle, IDLE);
    check(lf[0] == 8'h34, "R10", "second request taken after idle", int'(lf[0]), 'h34);
  endtask

  initial begin
    t_reset();
    t_boot();
    t_write(5'd3, 2'd3, 32'hC3B2A190, 8'd2);
    t_read(5'd3, 2'd3, 8'd1);
    t_read(5'd10, 2'd0, 8'd6);
    t_write(5'd31, 2'd1, 32'h0000_7E81, 8'd6);
    t_read(5'd31, 2'd1, 8'd3);
    t_back_to_back();
    check(mosi_viol == 0, "R7", "MOSI moves at falling SCLK", mosi_viol, 0);
    check(hw_viol == 0, "R7", "SCLK high phase length", hw_viol, 0);
    check(start_viol == 0, "R8", "START high with CS low", start_viol, 0);
    check(ready_viol == 0, "R10", "ready high with CS low", ready_viol, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule